// File: doc/BRIEF.md
# Monochrome to 24bpp bit tripler

This block is a streaming converter for drawing one-bit glyph or stencil images into a packed 24-bit-per-pixel surface that the drawing engine treats as an 8-bit-per-pixel surface. Every source pixel then covers three destination bytes. The mono expansion logic consumes one bit per destination byte, so each source bit must appear three times in a row in the host data stream.

A job starts with a one-cycle `start` pulse that latches the image width in pixels and the height in rows. Source rows arrive as bytes on a valid/ready stream. Each row occupies a whole number of bytes. The tripled bits leave as 32-bit words on a second valid/ready stream, and `done` pulses once the final word has been taken. Back-pressure on the output travels back to the input without dropping any bits.

Top module: `mono_tripler`

## Requirements
- R1: Each source pixel bit appears in the output as three consecutive identical bits, and the pixels keep their order.
- R2: Within a source byte, pixels are taken from bit 7 down to bit 0.
- R3: Output bytes are filled from bit 7 down to bit 0.
- R4: When a row's pixel count runs out, the unused bits of the current source byte are dropped and the next row begins with a fresh source byte. A job therefore consumes exactly ceil(width/8) × height source bytes.
- R5: At the end of each row, the remaining bits of the current output byte are zero, and the next row begins in the following output byte.
- R6: Output bytes are packed four to a word. The first byte goes in bits 7:0, the next in 15:8, then 23:16, then 31:24. Row boundaries do not break a word.
- R7: When the total output byte count is not a multiple of four, the last word is still sent, and its unused upper bytes are zero.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` stays unchanged. No data is lost or repeated.
- R9: `done` is high for exactly one cycle: the cycle right after the clock edge at which the last word is accepted.
- R10: A `start` pulse while a job is running has no effect on that job. A `start` pulse with a width or height of zero is ignored.
- R11: Outside a job, `in_ready` and `out_valid` are low.
- R12: After reset, `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job start; latches the dimensions |
| width_px | input | 12 | Image width in pixels (1 to 4095) |
| height_rows | input | 12 | Image height in rows (1 to 4095) |
| in_valid | input | 1 | Source byte valid |
| in_byte | input | 8 | Source byte, leftmost pixel in bit 7 |
| in_ready | output | 1 | Block can take a source byte |
| out_valid | output | 1 | Output word valid |
| out_word | output | 32 | Tripled data, first byte in bits 7:0 |
| out_ready | input | 1 | Consumer takes the word |
| done | output | 1 | One-cycle pulse after the last word is taken |

## Verification
Hand-worked single-byte images with one or eight pixels separate MSB-first reading from LSB-first reading and expose misplaced tripled bits. A three-pixel, four-row image shows whether the row tail of the source byte is dropped, whether the output byte is padded, and whether words carry over across rows. Wider images with an odd width and with a width that fills whole words compare every word against an independent bit-level model, one with a steady consumer and one with an irregular stall pattern. A stray `start` pulse during a job, and zero-dimension starts while idle, check that no such pulse disturbs the data, the source byte count or the `done` pulse.

// File: rtl/mono_tripler_pkg.sv
package mono_tripler_pkg;

   // Bits needed in the staging buffer: one partial byte plus one replicated pixel.
   function automatic int mt_stage_bits(input int byte_w, input int rep);
      return byte_w + rep - 1;
   endfunction

   // Counter width able to hold the value n itself.
   function automatic int mt_count_bits(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/mt_expand.sv
module mt_expand
   import mono_tripler_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int REP    = 3,
   parameter int DIM_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [DIM_W-1:0]  width_px,
   input  logic [DIM_W-1:0]  height_rows,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              in_ready,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data,
   output logic              byte_last,
   input  logic              byte_ready
);

   localparam int PW = mt_stage_bits(BYTE_W, REP);
   localparam int CW = mt_count_bits(PW);
   localparam int IW = mt_count_bits(BYTE_W);

   logic              active_q, have_q, flush_q;
   logic [BYTE_W-1:0] sr_q;
   logic [IW-1:0]     left_q;
   logic [DIM_W-1:0]  wid_q, pix_q, rows_q;
   logic [PW-1:0]     pend_q;
   logic [CW-1:0]     pcnt_q;

   logic              full_w, emit, take_pix;
   logic [PW-1:0]     rep_bits, appended;
   logic [CW-1:0]     sh;

   always_comb begin
      full_w     = pcnt_q >= CW'(BYTE_W);
      emit       = active_q && (full_w || (flush_q && pcnt_q != '0));
      take_pix   = active_q && !emit && !flush_q && have_q;
      in_ready   = active_q && !have_q && !flush_q;
      byte_valid = emit;
      byte_data  = pend_q[PW-1 -: BYTE_W];
      byte_last  = flush_q && (rows_q == DIM_W'(1)) && (pcnt_q <= CW'(BYTE_W));
      rep_bits   = PW'({REP{sr_q[BYTE_W-1]}});
      sh         = CW'(PW - REP) - pcnt_q;
      appended   = pend_q | (rep_bits << sh);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         have_q   <= 1'b0;
         flush_q  <= 1'b0;
         sr_q     <= '0;
         left_q   <= '0;
         wid_q    <= '0;
         pix_q    <= '0;
         rows_q   <= '0;
         pend_q   <= '0;
         pcnt_q   <= '0;
      end else if (go) begin
         active_q <= 1'b1;
         have_q   <= 1'b0;
         flush_q  <= 1'b0;
         wid_q    <= width_px;
         pix_q    <= width_px;
         rows_q   <= height_rows;
         pend_q   <= '0;
         pcnt_q   <= '0;
      end else begin
         if (in_valid && in_ready) begin
            sr_q   <= in_byte;
            left_q <= IW'(BYTE_W);
            have_q <= 1'b1;
         end
         if (emit) begin
            if (byte_ready) begin
               pend_q <= pend_q << BYTE_W;
               pcnt_q <= full_w ? pcnt_q - CW'(BYTE_W) : '0;
            end
         end else if (flush_q) begin
            flush_q <= 1'b0;
            if (rows_q == DIM_W'(1)) begin
               active_q <= 1'b0;
            end else begin
               rows_q <= rows_q - DIM_W'(1);
               pix_q  <= wid_q;
            end
         end else if (take_pix) begin
            pend_q <= appended;
            pcnt_q <= pcnt_q + CW'(REP);
            sr_q   <= sr_q << 1;
            left_q <= left_q - IW'(1);
            pix_q  <= pix_q - DIM_W'(1);
            if (pix_q == DIM_W'(1)) begin
               flush_q <= 1'b1;
               have_q  <= 1'b0;
            end else if (left_q == IW'(1)) begin
               have_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/mt_pack.sv
module mt_pack #(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         byte_valid,
   input  logic [BYTE_W-1:0]            byte_data,
   input  logic                         byte_last,
   output logic                         byte_ready,
   output logic                         word_valid,
   output logic [BYTE_W*WORD_BYTES-1:0] word_data,
   output logic                         word_last,
   input  logic                         word_ready
);

   localparam int WW = BYTE_W * WORD_BYTES;
   localparam int IW = $clog2(WORD_BYTES);

   logic [IW-1:0]     idx_q;
   logic [BYTE_W-1:0] lane_q [WORD_BYTES];
   logic [WW-1:0]     word_d;
   logic              take, complete;

   always_comb begin
      byte_ready = !word_valid || word_ready;
      take       = byte_valid && byte_ready;
      complete   = (idx_q == IW'(WORD_BYTES - 1)) || byte_last;
   end

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      always_comb word_d[g*BYTE_W +: BYTE_W] = (idx_q == IW'(g)) ? byte_data : lane_q[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lane_q[g] <= '0;
         end else if (take) begin
            if (complete)
               lane_q[g] <= '0;
            else if (idx_q == IW'(g))
               lane_q[g] <= byte_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q      <= '0;
         word_valid <= 1'b0;
         word_data  <= '0;
         word_last  <= 1'b0;
      end else begin
         if (word_valid && word_ready)
            word_valid <= 1'b0;
         if (take) begin
            if (complete) begin
               idx_q      <= '0;
               word_valid <= 1'b1;
               word_data  <= word_d;
               word_last  <= byte_last;
            end else begin
               idx_q <= idx_q + IW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/mono_tripler.sv
module mono_tripler #(
   parameter int DIM_W      = 12,
   parameter int BYTE_W     = 8,
   parameter int REP        = 3,
   parameter int WORD_BYTES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [DIM_W-1:0]             width_px,
   input  logic [DIM_W-1:0]             height_rows,
   input  logic                         in_valid,
   input  logic [BYTE_W-1:0]            in_byte,
   output logic                         in_ready,
   output logic                         out_valid,
   output logic [BYTE_W*WORD_BYTES-1:0] out_word,
   input  logic                         out_ready,
   output logic                         done
);

   if (REP < 1 || REP > BYTE_W) begin : g_bad_rep
      $fatal(1, "REP must lie between 1 and BYTE_W");
   end
   if (WORD_BYTES < 2) begin : g_bad_word
      $fatal(1, "WORD_BYTES must be at least 2");
   end
   if (DIM_W < 1) begin : g_bad_dim
      $fatal(1, "DIM_W must be at least 1");
   end

   logic              busy_q, go;
   logic              bv, bl, br, pk_last;
   logic [BYTE_W-1:0] bd;
   logic              last_take;

   always_comb begin
      go        = start && !busy_q && (width_px != '0) && (height_rows != '0);
      last_take = out_valid && out_ready && pk_last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= last_take;
         if (go)
            busy_q <= 1'b1;
         else if (last_take)
            busy_q <= 1'b0;
      end
   end

   mt_expand #(.BYTE_W(BYTE_W), .REP(REP), .DIM_W(DIM_W)) u_expand (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .width_px   (width_px),
      .height_rows(height_rows),
      .in_valid   (in_valid),
      .in_byte    (in_byte),
      .in_ready   (in_ready),
      .byte_valid (bv),
      .byte_data  (bd),
      .byte_last  (bl),
      .byte_ready (br)
   );

   mt_pack #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (bv),
      .byte_data  (bd),
      .byte_last  (bl),
      .byte_ready (br),
      .word_valid (out_valid),
      .word_data  (out_word),
      .word_last  (pk_last),
      .word_ready (out_ready)
   );

endmodule

// File: rtl/mono_tripler_chk.sv
module mono_tripler_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_word,
   input logic              out_ready,
   input logic              done,
   input logic              busy,
   input logic              word_last
);

   p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(out_valid && out_ready && word_last));

   p_idle_no_in_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !in_ready);

   p_idle_no_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !out_valid);

endmodule

bind mono_tripler mono_tripler_chk #(.WORD_W(BYTE_W*WORD_BYTES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_word (out_word),
   .out_ready(out_ready),
   .done     (done),
   .busy     (busy_q),
   .word_last(pk_last)
);

// File: tb/mono_tripler_tb_top.sv
module mono_tripler_tb_top;

   logic        clk = 1'b0;
   logic        rst_n, start, in_valid, in_ready, out_valid, out_ready, done;
   logic [11:0] width_px, height_rows;
   logic [7:0]  in_byte;
   logic [31:0] out_word;

   int checks = 0, fails = 0, fed_n = 0, got_n = 0, exp_n = 0;
   logic [7:0]  src_mem [0:511];
   logic [31:0] exp_w   [0:1023];
   logic [31:0] got_w   [0:1023];

   always #4 clk = ~clk;

   mono_tripler dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .width_px(width_px),
      .height_rows(height_rows), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .out_valid(out_valid), .out_word(out_word),
      .out_ready(out_ready), .done(done)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic fill_src(input int n, input int seed);
      for (int i = 0; i < n; i++) src_mem[i] = 8'((i * 73 + seed * 29) ^ (i >> 2) ^ seed);
   endtask

   // Bit-level model built from the requirements (R1..R7)
   task automatic build_expect(input int w, input int h);
      logic [7:0] ob [0:4095];
      logic [7:0] cur;
      int nb, pos, bpr;
      logic b;
      bpr = (w + 7) / 8;
      nb  = 0;
      for (int r = 0; r < h; r++) begin
         cur = '0; pos = 0;
         for (int p = 0; p < w; p++) begin
            b = src_mem[r * bpr + p / 8][7 - (p % 8)];
            for (int k = 0; k < 3; k++) begin
               cur[7 - pos] = b;
               pos++;
               if (pos == 8) begin ob[nb] = cur; nb++; cur = '0; pos = 0; end
            end
         end
         if (pos > 0) begin ob[nb] = cur; nb++; end
      end
      exp_n = (nb + 3) / 4;
      for (int i = 0; i < exp_n; i++) begin
         exp_w[i] = '0;
         for (int j = 0; j < 4; j++)
            if (i * 4 + j < nb) exp_w[i][j*8 +: 8] = ob[i * 4 + j];
      end
   endtask

   task automatic feeder(input int n);
      int k, cyc;
      k = 0; cyc = 0;
      while (k < n && cyc < 20000) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_byte  = src_mem[k];
         if (in_ready) k++;
         cyc++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      fed_n = k;
   endtask

   task automatic collector(input int want, input int mode, input string tag);
      logic [7:0]  lf;
      logic [31:0] held;
      bit          pend_chk, early;
      int          cyc;
      lf = 8'h5A; pend_chk = 0; early = 0; cyc = 0; got_n = 0; held = '0;
      while (got_n < want && cyc < 40000) begin
         @(negedge clk);
         cyc++;
         if (done) early = 1;
         if (pend_chk) begin
            chk(out_valid && out_word == held, {tag, " R8 word held under stall"}, out_word, held);
            pend_chk = 0;
         end
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         out_ready = (mode == 0) ? 1'b1 : (lf[0] | lf[2]);
         if (out_valid) begin
            if (out_ready) begin got_w[got_n] = out_word; got_n++; end
            else begin held = out_word; pend_chk = 1; end
         end
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk(done == 1'b1, {tag, " R9 done after last word"}, 32'(done), 1);
      chk(!early, {tag, " R9 no early done"}, 32'(early), 0);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R9 done lasts one cycle"}, 32'(done), 0);
      repeat (3) @(negedge clk);
      chk(!out_valid && !in_ready, {tag, " R11 idle after job"}, {30'd0, out_valid, in_ready}, 0);
   endtask

   task automatic run_job(input int w, input int h, input int mode, input bit interfere, input string tag);
      int nbytes;
      nbytes = ((w + 7) / 8) * h;
      build_expect(w, h);
      @(negedge clk);
      start = 1'b1; width_px = 12'(w); height_rows = 12'(h);
      @(negedge clk);
      start = 1'b0;
      fork
         feeder(nbytes);
         collector(exp_n, mode, tag);
         begin
            if (interfere) begin
               repeat (6) @(negedge clk);
               start = 1'b1; width_px = 12'd1; height_rows = 12'd1;
               @(negedge clk);
               start = 1'b0;
            end
         end
      join
      chk(fed_n == nbytes, {tag, " R4 source byte count"}, 32'(fed_n), 32'(nbytes));
      chk(got_n == exp_n, {tag, " R7 word count"}, 32'(got_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < got_n; i++)
         chk(got_w[i] == exp_w[i], $sformatf("%s R1 R6 word %0d", tag, i), got_w[i], exp_w[i]);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!in_ready && !out_valid && !done, "R12 reset state",
          {29'd0, in_ready, out_valid, done}, 0);
   endtask

   task automatic t_one_pixel();
      src_mem[0] = 8'h80;
      run_job(1, 1, 0, 0, "one_px_set");
      chk(got_w[0] == 32'h0000_00E0, "R3 R7 single set pixel", got_w[0], 32'h0000_00E0);
      src_mem[0] = 8'h7F;
      run_job(1, 1, 0, 0, "one_px_clear");
      chk(got_w[0] == 32'h0, "R4 tail bits dropped", got_w[0], 0);
   endtask

   task automatic t_full_byte();
      src_mem[0] = 8'hA5;
      run_job(8, 1, 0, 0, "byte_a5");
      chk(got_w[0] == 32'h00C7_81E3, "R2 R3 msb first tripling", got_w[0], 32'h00C7_81E3);
   endtask

   task automatic t_rows();
      src_mem[0] = 8'hA0; src_mem[1] = 8'h5F; src_mem[2] = 8'hE0; src_mem[3] = 8'h00;
      run_job(3, 4, 0, 0, "rows3x4");
      chk(got_w[0] == 32'h001C_80E3, "R5 R6 row pad and carry", got_w[0], 32'h001C_80E3);
      chk(got_w[1] == 32'h0000_80FF, "R5 R7 row pad last word", got_w[1], 32'h0000_80FF);
   endtask

   task automatic t_stall();
      fill_src(10, 3);
      run_job(13, 5, 1, 0, "stall13x5");
   endtask

   task automatic t_wide();
      fill_src(39, 7);
      run_job(100, 3, 0, 0, "wide100x3");
      fill_src(4, 11);
      run_job(32, 1, 1, 0, "aligned32");
   endtask

   task automatic t_start_ignored();
      fill_src(100, 5);
      run_job(40, 20, 1, 1, "busy_start");
      @(negedge clk);
      start = 1'b1; width_px = 12'd0; height_rows = 12'd5;
      @(negedge clk);
      start = 1'b1; width_px = 12'd5; height_rows = 12'd0;
      @(negedge clk);
      start = 1'b0;
      repeat (10) begin
         @(negedge clk);
         chk(!in_ready && !out_valid && !done, "R10 zero dimension start ignored",
             {29'd0, in_ready, out_valid, done}, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_byte = '0;
      out_ready = 1'b1; width_px = '0; height_rows = '0;
      repeat (4) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_one_pixel();
      t_full_byte();
      t_rows();
      t_stall();
      t_wide();
      t_start_ignored();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule